// File: doc/BRIEF.md
# Power-of-Two Neuron Activation Unit

This unit forms the output nonlinearity of a neural processing element. It takes the accumulated dot product as a sign-magnitude number below 16 in magnitude and returns a sign-magnitude fraction strictly inside (-1, 1). A mode input chooses one of two curves. The squashing curve approximates sgn(x)·(1 − 2^−|x|) and is used by perceptron-style neurons. The bell curve approximates 2^−|x| and is used by radial-basis neurons.

Both curves are piecewise linear between integer points of |x|. They are built only from right shifts. The integer part of |x| sets the shift distance, and the fill bit depends on the mode. There are no multipliers, no lookup tables and no exponential logic. The result is registered once, so a new operand can be presented every clock cycle.

Top module: `pow2_activation`

## Requirements
- R1: While the synchronized reset is active, out_sign and out_mag are 0.
- R2: Each output is registered. A result appears on the outputs one clock edge after its operand is sampled, and stays unchanged until the next edge.
- R3: In squashing mode (in_mode = 0) with integer part i ≥ 1 and fraction field f, let h = f·2^(16−12−1), which is the half fraction in units of 2^−16. Then out_mag = 65536 − ceil((65536 − h) / 2^i). This is the half fraction shifted right by i with ones entering at the top, with the low bits truncated.
- R4: In squashing mode, out_sign equals in_sign.
- R5: In bell mode (in_mode = 1), out_mag = floor((65535 − h) / 2^i). This is the bitwise complement of the half fraction shifted right by i with zeros entering at the top.
- R6: In bell mode, out_sign is 0 for either value of in_sign.
- R7: In squashing mode with i = 0, out_mag equals h, so its top bit is 0.
- R8: At the largest integer part (i = 15), the squashing magnitude has bits 15 down to 1 all set, and the bell magnitude is at most 1.
- R9: Field layout: in_frac carries weight 2^−12 per LSB and out_mag carries weight 2^−16 per LSB. Mode code 0 selects squashing and code 1 selects bell. As a result, the operand 0 gives magnitude 0x0000 in squashing mode and 0xFFFF in bell mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_mode | input | 1 | Curve select: 0 squashing, 1 bell |
| in_sign | input | 1 | Sign of the accumulated sum (1 = negative) |
| in_int | input | 4 | Integer part of the magnitude |
| in_frac | input | 12 | Fractional part of the magnitude |
| out_sign | output | 1 | Sign of the result |
| out_mag | output | 16 | Magnitude of the result, all fraction bits |

## Verification
Both the sign and the magnitude come out of the same output register. Each result is therefore due exactly one rising edge after its operand is sampled. The bench drives a new operand on every falling edge. On the next falling edge, before it drives again, it compares the outputs with the value it expected for the previous operand. This keeps each comparison half a period away from the edge that loads the result. One directed check also reads the outputs just before that edge, to confirm the old value is still held. All 2·16·4096 mode, integer and fraction codes are swept with a random sign, followed by seeded random operands and a short list of directed corner cases.

// File: rtl/pow2_act_pkg.sv
package pow2_act_pkg;
  typedef enum logic {
    CURVE_SQUASH = 1'b0,
    CURVE_BELL   = 1'b1
  } curve_e;
endpackage

// File: rtl/pow2_reset_sync.sv
module pow2_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pow2_half_frac.sv
module pow2_half_frac #(
  parameter int FRAC_W = 12,
  parameter int MAG_W  = 16
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [MAG_W-1:0]  half_o,
  output logic [MAG_W-1:0]  half_inv_o
);
  localparam int PAD_W = MAG_W - FRAC_W - 1;

  // halve: one zero in at the top, fraction aligned under it
  assign half_o     = {1'b0, frac_i, {PAD_W{1'b0}}};
  // 1 - frac/2 approximated by the one's complement of the half fraction
  assign half_inv_o = ~half_o;
endmodule

// File: rtl/pow2_fill_shifter.sv
module pow2_fill_shifter #(
  parameter int W    = 16,
  parameter int SH_W = 4
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            fill_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    always_comb begin
      if (amt_i[k]) stage[k+1] = {{DIST{fill_i}}, stage[k][W-1:DIST]};
      else          stage[k+1] = stage[k];
    end
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/pow2_activation.sv
module pow2_activation #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 12,
  parameter int MAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_mode,
  input  logic              in_sign,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_frac,
  output logic              out_sign,
  output logic [MAG_W-1:0]  out_mag
);
  import pow2_act_pkg::*;

  logic             rst_sync_n;
  logic [MAG_W-1:0] half;
  logic [MAG_W-1:0] half_inv;
  logic [MAG_W-1:0] squash_mag;
  logic [MAG_W-1:0] bell_mag;
  logic             sign_d;
  logic [MAG_W-1:0] mag_d;
  logic             load_en;
  curve_e           curve;

  pow2_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pow2_half_frac #(.FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_half (
    .frac_i     (in_frac),
    .half_o     (half),
    .half_inv_o (half_inv)
  );

  pow2_fill_shifter #(.W(MAG_W), .SH_W(INT_W)) u_squash_sh (
    .data_i (half),
    .amt_i  (in_int),
    .fill_i (1'b1),
    .data_o (squash_mag)
  );

  pow2_fill_shifter #(.W(MAG_W), .SH_W(INT_W)) u_bell_sh (
    .data_i (half_inv),
    .amt_i  (in_int),
    .fill_i (1'b0),
    .data_o (bell_mag)
  );

  assign curve   = curve_e'(in_mode);
  assign load_en = 1'b1;

  always_comb begin
    unique case (curve)
      CURVE_BELL: begin
        sign_d = 1'b0;
        mag_d  = bell_mag;
      end
      default: begin
        sign_d = in_sign;
        mag_d  = squash_mag;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_sign <= 1'b0;
      out_mag  <= '0;
    end else if (load_en) begin
      out_sign <= sign_d;
      out_mag  <= mag_d;
    end
  end
endmodule

// File: rtl/pow2_activation_chk.sv
module pow2_activation_chk #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 12,
  parameter int MAG_W  = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_mode,
  input logic              in_sign,
  input logic [INT_W-1:0]  in_int,
  input logic [FRAC_W-1:0] in_frac,
  input logic              out_sign,
  input logic [MAG_W-1:0]  out_mag
);
  localparam int PAD_W = MAG_W - FRAC_W - 1;
  localparam logic [INT_W-1:0] INT_MAX = '1;

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_sync_n |-> (out_mag == '0 && !out_sign));

  a_r4_squash_sign: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_mode |=> out_sign == $past(in_sign));

  a_r6_bell_sign: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_mode |=> !out_sign);

  a_r7_squash_int0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_mode && in_int == '0) |=> out_mag == {1'b0, $past(in_frac), {PAD_W{1'b0}}});

  a_r3_squash_msb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_mode && in_int != '0) |=> out_mag[MAG_W-1]);

  a_r5_bell_msb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_mode && in_int != '0) |=> !out_mag[MAG_W-1]);

  a_r8_squash_top: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_mode && in_int == INT_MAX) |=> &out_mag[MAG_W-1:1]);

  a_r8_bell_floor: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_mode && in_int == INT_MAX) |=> out_mag[MAG_W-1:1] == '0);

  a_r9_bell_peak: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_mode && in_int == '0 && in_frac == '0) |=> &out_mag);
endmodule

bind pow2_activation pow2_activation_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .MAG_W(MAG_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_mode    (in_mode),
  .in_sign    (in_sign),
  .in_int     (in_int),
  .in_frac    (in_frac),
  .out_sign   (out_sign),
  .out_mag    (out_mag)
);

// File: tb/test_pow2_activation.sv
module test_pow2_activation;
  logic        clk;
  logic        rst_n;
  logic        in_mode;
  logic        in_sign;
  logic [3:0]  in_int;
  logic [11:0] in_frac;
  logic        out_sign;
  logic [15:0] out_mag;

  int checks = 0;
  int errors = 0;

  logic        pend = 1'b0;
  logic        pend_sign;
  logic [15:0] pend_mag;
  logic        pend_mode;
  logic [3:0]  pend_int;

  pow2_activation i_pow2_activation (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_mode  (in_mode),
    .in_sign  (in_sign),
    .in_int   (in_int),
    .in_frac  (in_frac),
    .out_sign (out_sign),
    .out_mag  (out_mag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] ref_mag(input logic mode, input int i, input int f);
    int h;
    int q;
    h = f * 8;
    if (mode) return 16'((65535 - h) / (1 << i));
    q = (65536 - h + (1 << i) - 1) / (1 << i);
    return 16'(65536 - q);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic flush();
    string mtag;
    if (pend) begin
      if (pend_mode) mtag = "R5";
      else if (pend_int == 0) mtag = "R7";
      else if (pend_int == 15) mtag = "R8";
      else mtag = "R3";
      check(pend_mode ? "R6 sign" : "R4 sign", out_sign, pend_sign);
      check({mtag, " mag"}, out_mag, pend_mag);
    end
  endtask

  task automatic apply(input logic m, input logic s, input int i, input int f);
    @(negedge clk);
    flush();
    in_mode   = m;
    in_sign   = s;
    in_int    = 4'(i);
    in_frac   = 12'(f);
    pend      = 1'b1;
    pend_mode = m;
    pend_int  = 4'(i);
    pend_sign = m ? 1'b0 : s;
    pend_mag  = ref_mag(m, i, f);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int unused;
    rst_n   = 1'b0;
    in_mode = 1'b0;
    in_sign = 1'b1;
    in_int  = 4'd7;
    in_frac = 12'hABC;
    unused  = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    check("R1 reset mag", out_mag, 0);
    check("R1 reset sign", out_sign, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: encoding corners
    apply(1'b0, 1'b0, 0, 0);
    apply(1'b1, 1'b1, 0, 0);
    @(negedge clk);
    check("R9 bell peak", out_mag, 16'hFFFF);
    flush();
    pend = 1'b0;

    // R2: result held until the loading edge
    in_mode = 1'b1; in_sign = 1'b0; in_int = 4'd15; in_frac = 12'hFFF;
    #9;
    check("R2 hold before edge", out_mag, 16'hFFFF);
    @(negedge clk);
    check("R2 one edge later", out_mag, ref_mag(1'b1, 15, 4095));

    // directed corners
    apply(1'b0, 1'b1, 15, 4095);
    apply(1'b0, 1'b1, 0, 4095);
    apply(1'b1, 1'b1, 15, 0);
    apply(1'b0, 1'b0, 1, 0);
    apply(1'b1, 1'b0, 1, 4095);

    // full sweep of every code, random sign
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++)
        for (int f = 0; f < 4096; f++)
          apply(1'(m), 1'($urandom & 1), i, f);

    // seeded random operands
    for (int n = 0; n < 3000; n++)
      apply(1'($urandom & 1), 1'($urandom & 1), int'($urandom % 16), int'($urandom % 4096));

    @(negedge clk);
    flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule